// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU bus with a 16-bit address and a large cartridge ROM plus optional external RAM. CPU writes into the ROM address range do not reach any storage. The block decodes them as control writes that open or close the RAM, select the ROM bank, select the RAM bank, and store a banking mode. From the stored state it forms the physical ROM address for both ROM windows, and the physical RAM address and write strobe for the external RAM window. It also returns the byte the CPU sees when it reads the RAM window. The ROM and RAM arrays themselves sit outside the block.

Control state is built around two small state machines. The RAM gate has the states `RAM_LOCKED` and `RAM_OPEN`. A write to the enable range moves it to `RAM_OPEN` when the low nibble of the data is 0xA. Any other value moves it to `RAM_LOCKED`. Reset enters `RAM_LOCKED`. The banking-mode register has the states `MODE_SIMPLE` (reset) and `MODE_ALT`. A mode write moves it to the state given by data bit 0. The ROM bank register is corrected as it is loaded: a request for bank 0 becomes bank 1, and a request above the highest bank present becomes that highest bank. The bank count, the RAM bank count and the presence of RAM are parameters.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the switchable ROM window maps to bank 1, the RAM bank is 0, RAM is locked (RAM-window reads give 0xFF) and the mode is `MODE_SIMPLE`.
- R2: For cpu_addr 0x0000–0x3FFF, rom_addr equals cpu_addr (bank 0).
- R3: A write with cpu_addr in 0x2000–0x3FFF loads the ROM bank from cpu_wdata[4:0]. For cpu_addr 0x4000–0x7FFF, rom_addr = bank × 0x4000 + (cpu_addr − 0x4000).
- R4: A requested ROM bank of 0 is stored as bank 1.
- R5: A requested ROM bank greater than ROM_BANKS−1 is stored as ROM_BANKS−1.
- R6: A write with cpu_addr in 0x4000–0x5FFF loads the RAM bank from cpu_wdata[1:0]. For cpu_addr 0xA000–0xBFFF, ram_addr = bank × 0x2000 + (cpu_addr − 0xA000).
- R7: A write with cpu_addr in 0x0000–0x1FFF opens RAM when cpu_wdata[3:0] is 0xA and locks it for any other value.
- R8: ram_we is high only while cpu_wr is high, cpu_addr is in 0xA000–0xBFFF, RAM is open and HAS_RAM is 1.
- R9: cpu_rdata equals ram_rdata when cpu_addr is in 0xA000–0xBFFF, RAM is open and HAS_RAM is 1. In every other case it is 0xFF.
- R10: A write with cpu_addr in 0x6000–0x7FFF stores cpu_wdata[0] as the mode and changes neither the ROM bank, the RAM bank nor the RAM gate.
- R11: Writes with cpu_addr in 0x8000–0x9FFF or 0xC000–0xFFFF change no control state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled at the rising edge |
| ram_rdata | input | 8 | Byte from the external RAM array |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| ram_addr | output | RAM_AW | Physical RAM byte address |
| ram_we | output | 1 | External RAM write strobe |
| cpu_rdata | output | 8 | Byte returned for a read of the RAM window |

## Verification
Bank clamping depends on the data byte a write carries, so a clamp or remap slip is seen only at one particular value of that byte. Likewise, only one low nibble out of sixteen opens the RAM. The bench therefore sweeps every 5-bit ROM bank request (with junk in the upper bits), every byte value in the enable range, and every RAM bank. After each write it probes the mapped addresses and compares them with arithmetic expectations. A second instance with HAS_RAM set to 0 shares the same bus, so the case where RAM is absent yet opened is reached with the same stimulus.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    // Which control register a write in the low half of the map targets
    typedef enum logic [2:0] {
        REG_NONE,
        REG_RAM_GATE,
        REG_ROM_BANK,
        REG_RAM_BANK,
        REG_MODE
    } reg_sel_e;

    // Which data window a CPU address falls in
    typedef enum logic [1:0] {
        WIN_FIXED,
        WIN_SWITCH,
        WIN_XRAM,
        WIN_OTHER
    } window_e;

    // RAM gate state machine
    typedef enum logic [0:0] {
        RAM_LOCKED,
        RAM_OPEN
    } ram_gate_e;

    // Banking mode state machine
    typedef enum logic [0:0] {
        MODE_SIMPLE,
        MODE_ALT
    } bank_mode_e;

    localparam int ROM_OFS_W  = 14;   // 16 KiB ROM bank
    localparam int RAM_OFS_W  = 13;   // 8 KiB RAM bank
    localparam int REQ_W      = 5;    // width of a ROM bank request
    localparam int RAMSEL_W   = 2;    // width of the RAM bank register
    localparam logic [3:0] OPEN_KEY = 4'hA;

    function automatic reg_sel_e reg_select(input logic [15:0] a);
        reg_sel_e r;
        unique case (a[15:13])
            3'b000:  r = REG_RAM_GATE;
            3'b001:  r = REG_ROM_BANK;
            3'b010:  r = REG_RAM_BANK;
            3'b011:  r = REG_MODE;
            default: r = REG_NONE;
        endcase
        return r;
    endfunction

    function automatic window_e window_of(input logic [15:0] a);
        window_e w;
        if (a[15:14] == 2'b00)       w = WIN_FIXED;
        else if (a[15:14] == 2'b01)  w = WIN_SWITCH;
        else if (a[15:13] == 3'b101) w = WIN_XRAM;
        else                         w = WIN_OTHER;
        return w;
    endfunction

endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
    import cart_bank_pkg::*;
(
    input  logic [15:0] addr,
    input  logic        wr,
    output reg_sel_e    reg_sel,
    output logic        reg_wr,
    output window_e     window
);

    always_comb begin
        reg_sel = reg_select(addr);
        window  = window_of(addr);
        reg_wr  = wr && (reg_sel != REG_NONE);
    end

endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 12,
    localparam int RB_W     = $clog2(ROM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  reg_sel_e          reg_sel,
    input  logic [7:0]        wdata,
    output logic [RB_W-1:0]   rom_bank,
    output logic [RAMSEL_W-1:0] ram_bank,
    output logic              ram_open,
    output bank_mode_e        mode
);

    localparam logic [REQ_W-1:0] TOP_BANK = REQ_W'(ROM_BANKS - 1);
    localparam logic [REQ_W-1:0] LOW_BANK = REQ_W'(1);

    ram_gate_e  gate_q, gate_d;
    bank_mode_e mode_q, mode_d;
    logic [REQ_W-1:0]    req_fix;
    logic [RB_W-1:0]     rom_q;
    logic [RAMSEL_W-1:0] ram_q;

    // RAM gate: next state
    always_comb begin
        gate_d = gate_q;
        if (reg_wr && reg_sel == REG_RAM_GATE) begin
            unique case (gate_q)
                RAM_LOCKED: gate_d = (wdata[3:0] == OPEN_KEY) ? RAM_OPEN : RAM_LOCKED;
                RAM_OPEN:   gate_d = (wdata[3:0] == OPEN_KEY) ? RAM_OPEN : RAM_LOCKED;
            endcase
        end
    end

    // Banking mode: next state
    always_comb begin
        mode_d = mode_q;
        if (reg_wr && reg_sel == REG_MODE) begin
            unique case (mode_q)
                MODE_SIMPLE: mode_d = wdata[0] ? MODE_ALT : MODE_SIMPLE;
                MODE_ALT:    mode_d = wdata[0] ? MODE_ALT : MODE_SIMPLE;
            endcase
        end
    end

    // ROM bank request correction: cap first, then lift zero
    always_comb begin
        req_fix = wdata[REQ_W-1:0];
        if (req_fix > TOP_BANK) req_fix = TOP_BANK;
        if (req_fix == '0)      req_fix = LOW_BANK;
    end

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= RAM_LOCKED;
            mode_q <= MODE_SIMPLE;
        end else begin
            gate_q <= gate_d;
            mode_q <= mode_d;
        end
    end

    // Bank registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rom_q <= RB_W'(1);
            ram_q <= '0;
        end else if (reg_wr) begin
            if (reg_sel == REG_ROM_BANK) rom_q <= RB_W'(req_fix);
            if (reg_sel == REG_RAM_BANK) ram_q <= wdata[RAMSEL_W-1:0];
        end
    end

    // Outputs
    always_comb begin
        rom_bank = rom_q;
        ram_bank = ram_q;
        ram_open = (gate_q == RAM_OPEN);
        mode     = mode_q;
    end

endmodule

// File: rtl/cart_map.sv
module cart_map
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 12,
    parameter int RAM_BANKS = 4,
    parameter bit HAS_RAM   = 1'b1,
    localparam int RB_W     = $clog2(ROM_BANKS),
    localparam int RAB_W    = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
    localparam int ROM_AW   = RB_W + ROM_OFS_W,
    localparam int RAM_AW   = RAB_W + RAM_OFS_W
) (
    input  logic [15:0]         addr,
    input  logic                wr,
    input  window_e             window,
    input  logic [RB_W-1:0]     rom_bank,
    input  logic [RAMSEL_W-1:0] ram_bank,
    input  logic                ram_open,
    input  logic [7:0]          ram_rdata,
    output logic [ROM_AW-1:0]   rom_addr,
    output logic [RAM_AW-1:0]   ram_addr,
    output logic                ram_we,
    output logic [7:0]          rdata
);

    logic ram_live;

    generate
        if (HAS_RAM) begin : g_ram
            assign ram_live = ram_open;
        end else begin : g_noram
            assign ram_live = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (window)
            WIN_SWITCH: rom_addr = {rom_bank, addr[ROM_OFS_W-1:0]};
            default:    rom_addr = {{RB_W{1'b0}}, addr[ROM_OFS_W-1:0]};
        endcase
        ram_addr = {ram_bank[RAB_W-1:0], addr[RAM_OFS_W-1:0]};
        ram_we   = wr && (window == WIN_XRAM) && ram_live;
        rdata    = ((window == WIN_XRAM) && ram_live) ? ram_rdata : 8'hFF;
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 12,
    parameter int RAM_BANKS = 4,
    parameter bit HAS_RAM   = 1'b1,
    localparam int RB_W     = $clog2(ROM_BANKS),
    localparam int RAB_W    = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
    localparam int ROM_AW   = RB_W + ROM_OFS_W,
    localparam int RAM_AW   = RAB_W + RAM_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic [7:0]        ram_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        cpu_rdata
);

    reg_sel_e            reg_sel;
    logic                reg_wr;
    window_e             window;
    logic [RB_W-1:0]     rom_bank_q;
    logic [RAMSEL_W-1:0] ram_bank_q;
    logic                ram_open;
    bank_mode_e          mode_q;

    cart_addr_decode u_dec (
        .addr    (cpu_addr),
        .wr      (cpu_wr),
        .reg_sel (reg_sel),
        .reg_wr  (reg_wr),
        .window  (window)
    );

    cart_bank_regs #(.ROM_BANKS(ROM_BANKS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .wdata    (cpu_wdata),
        .rom_bank (rom_bank_q),
        .ram_bank (ram_bank_q),
        .ram_open (ram_open),
        .mode     (mode_q)
    );

    cart_map #(
        .ROM_BANKS (ROM_BANKS),
        .RAM_BANKS (RAM_BANKS),
        .HAS_RAM   (HAS_RAM)
    ) u_map (
        .addr      (cpu_addr),
        .wr        (cpu_wr),
        .window    (window),
        .rom_bank  (rom_bank_q),
        .ram_bank  (ram_bank_q),
        .ram_open  (ram_open),
        .ram_rdata (ram_rdata),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .rdata     (cpu_rdata)
    );

endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 12,
    parameter bit HAS_RAM   = 1'b1,
    localparam int RB_W     = $clog2(ROM_BANKS),
    localparam int ROM_AW   = RB_W + ROM_OFS_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic [15:0]         cpu_addr,
    input logic [7:0]          cpu_wdata,
    input logic                cpu_wr,
    input logic [ROM_AW-1:0]   rom_addr,
    input logic                ram_we,
    input logic [7:0]          cpu_rdata,
    input logic [RB_W-1:0]     rom_bank,
    input logic [RAMSEL_W-1:0] ram_bank,
    input logic                ram_open,
    input bank_mode_e          mode
);

    localparam logic [RB_W-1:0] TOP = RB_W'(ROM_BANKS - 1);

    AST_FIXED_IS_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> (rom_addr[ROM_AW-1:ROM_OFS_W] == '0)); // R2

    AST_BANK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b01) |-> (rom_addr[ROM_AW-1:ROM_OFS_W] != '0)); // R4

    AST_BANK_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b01) |-> (rom_addr[ROM_AW-1:ROM_OFS_W] <= TOP)); // R5

    AST_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (cpu_wr && ram_open && HAS_RAM && cpu_addr[15:13] == 3'b101)); // R8

    AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b101 && !ram_open) |-> (cpu_rdata == 8'hFF)); // R9

    AST_MODE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b011) |=>
            ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_open))); // R10

    AST_MODE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b011) |=>
            (mode == ($past(cpu_wdata[0]) ? MODE_ALT : MODE_SIMPLE))); // R10

    AST_HIGH_WRITES_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15]) |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_open))); // R11

endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(
    .ROM_BANKS (ROM_BANKS),
    .HAS_RAM   (HAS_RAM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .rom_addr  (rom_addr),
    .ram_we    (ram_we),
    .cpu_rdata (cpu_rdata),
    .rom_bank  (rom_bank_q),
    .ram_bank  (ram_bank_q),
    .ram_open  (ram_open),
    .mode      (mode_q)
);

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;

    localparam int NB     = 12;
    localparam int ROM_AW = 18;
    localparam int RAM_AW = 15;
    localparam logic [7:0] RD_PAT = 8'h5C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = 16'h0000;
    logic [7:0]        cpu_wdata = 8'h00;
    logic              cpu_wr = 1'b0;
    logic [7:0]        ram_rdata = RD_PAT;
    logic [ROM_AW-1:0] rom_addr, rom_addr_n;
    logic [RAM_AW-1:0] ram_addr, ram_addr_n;
    logic              ram_we, ram_we_n;
    logic [7:0]        cpu_rdata, cpu_rdata_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cart_bank_ctrl #(.ROM_BANKS(NB), .RAM_BANKS(4), .HAS_RAM(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .ram_rdata(ram_rdata), .rom_addr(rom_addr),
        .ram_addr(ram_addr), .ram_we(ram_we), .cpu_rdata(cpu_rdata));

    cart_bank_ctrl #(.ROM_BANKS(NB), .RAM_BANKS(4), .HAS_RAM(1'b0)) uut_nr (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .ram_rdata(ram_rdata), .rom_addr(rom_addr_n),
        .ram_addr(ram_addr_n), .ram_we(ram_we_n), .cpu_rdata(cpu_rdata_n));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0;
        #1;
    endtask

    function automatic int eff_bank(input int req);
        int b = req;
        if (b > NB - 1) b = NB - 1;
        if (b == 0) b = 1;
        return b;
    endfunction

    function automatic int rom_exp(input int bank, input logic [15:0] a);
        return bank * 16384 + (int'(a) - 16'h4000);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int cur_bank;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        probe(16'h4000);
        check(rom_addr == ROM_AW'(rom_exp(1, 16'h4000)), "R1 rom bank", int'(rom_addr), rom_exp(1, 16'h4000));
        probe(16'hA010);
        check(ram_addr == RAM_AW'(16'h0010), "R1 ram bank", int'(ram_addr), 16'h0010);
        check(cpu_rdata == 8'hFF, "R1 locked read", int'(cpu_rdata), 8'hFF);

        // R2: fixed window is bank 0
        for (int a = 0; a < 16'h4000; a += 16'h0777) begin
            probe(16'(a));
            check(rom_addr == ROM_AW'(a), "R2 fixed window", int'(rom_addr), a);
        end

        // R3, R4, R5: every 5-bit request, junk in upper bits
        for (int k = 0; k < 32; k++) begin
            bus_write(16'h2000 + 16'(k * 97), 8'(k) | 8'hE0);
            cur_bank = eff_bank(k);
            probe(16'h4000);
            check(rom_addr == ROM_AW'(rom_exp(cur_bank, 16'h4000)),
                  (k == 0) ? "R4 bank0 lift" : (k > NB - 1) ? "R5 cap" : "R3 bank load",
                  int'(rom_addr), rom_exp(cur_bank, 16'h4000));
            probe(16'h7FFF);
            check(rom_addr == ROM_AW'(rom_exp(cur_bank, 16'h7FFF)), "R3 window end",
                  int'(rom_addr), rom_exp(cur_bank, 16'h7FFF));
            probe(16'h1234);
            check(rom_addr == ROM_AW'(16'h1234), "R2 fixed after switch", int'(rom_addr), 16'h1234);
        end

        // R7: enable sweep over every byte
        for (int d = 0; d < 256; d++) begin
            bus_write(16'h0000 + 16'(d * 31), 8'(d));
            probe(16'hA000);
            check(cpu_rdata == (((d & 15) == 10) ? RD_PAT : 8'hFF), "R7 gate key",
                  int'(cpu_rdata), ((d & 15) == 10) ? RD_PAT : 8'hFF);
            check(cpu_rdata_n == 8'hFF, "R9 no-RAM read", int'(cpu_rdata_n), 8'hFF);
        end

        // R6, R8: RAM bank sweep with RAM open
        bus_write(16'h1FFF, 8'h3A);
        for (int b = 0; b < 8; b++) begin
            bus_write(16'h4000 + 16'(b * 1000), 8'(b) | 8'hF4);
            @(negedge clk);
            cpu_addr = 16'hA000 + 16'(b * 1021); cpu_wr = 1'b1;
            #1;
            check(ram_addr == RAM_AW'((b & 3) * 16'h2000 + b * 1021), "R6 ram addr",
                  int'(ram_addr), (b & 3) * 16'h2000 + b * 1021);
            check(ram_we == 1'b1, "R8 write strobe", int'(ram_we), 1);
            check(ram_we_n == 1'b0, "R8 no-RAM strobe", int'(ram_we_n), 0);
            @(negedge clk);
            cpu_wr = 1'b0;
        end

        // R9: reads outside the RAM window give 0xFF
        probe(16'hC000);
        check(cpu_rdata == 8'hFF, "R9 outside window", int'(cpu_rdata), 8'hFF);
        probe(16'hBFFF);
        check(cpu_rdata == RD_PAT, "R9 open read", int'(cpu_rdata), RD_PAT);

        // R8: strobe off with write outside window and with RAM locked
        @(negedge clk);
        cpu_addr = 16'hC123; cpu_wr = 1'b1; #1;
        check(ram_we == 1'b0, "R8 outside window", int'(ram_we), 0);
        @(negedge clk);
        cpu_wr = 1'b0;
        bus_write(16'h0ABC, 8'h0B);
        @(negedge clk);
        cpu_addr = 16'hA555; cpu_wr = 1'b1; #1;
        check(ram_we == 1'b0, "R8 locked", int'(ram_we), 0);
        @(negedge clk);
        cpu_wr = 1'b0;

        // R10: mode writes leave the mapping alone
        bus_write(16'h0000, 8'h0A);
        bus_write(16'h2000, 8'h05);
        bus_write(16'h4000, 8'h02);
        for (int m = 0; m < 4; m++) begin
            bus_write(16'h6000 + 16'(m * 2047), 8'(m * 85));
            probe(16'h5000);
            check(rom_addr == ROM_AW'(rom_exp(5, 16'h5000)), "R10 rom kept",
                  int'(rom_addr), rom_exp(5, 16'h5000));
            probe(16'hA001);
            check(ram_addr == RAM_AW'(2 * 16'h2000 + 1), "R10 ram kept",
                  int'(ram_addr), 2 * 16'h2000 + 1);
            check(cpu_rdata == RD_PAT, "R10 gate kept", int'(cpu_rdata), RD_PAT);
        end

        // R11: writes to the upper map change nothing
        bus_write(16'h8000, 8'h00);
        bus_write(16'h9FFF, 8'h1F);
        bus_write(16'hC000, 8'h00);
        bus_write(16'hFFFF, 8'h03);
        probe(16'h4ABC);
        check(rom_addr == ROM_AW'(rom_exp(5, 16'h4ABC)), "R11 rom kept",
              int'(rom_addr), rom_exp(5, 16'h4ABC));
        probe(16'hA002);
        check(ram_addr == RAM_AW'(2 * 16'h2000 + 2), "R11 ram kept",
              int'(ram_addr), 2 * 16'h2000 + 2);
        check(cpu_rdata == RD_PAT, "R11 gate kept", int'(cpu_rdata), RD_PAT);

        // R1: reset again restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe(16'h4000);
        check(rom_addr == ROM_AW'(rom_exp(1, 16'h4000)), "R1 re-reset rom", int'(rom_addr), rom_exp(1, 16'h4000));
        probe(16'hA000);
        check(cpu_rdata == 8'hFF, "R1 re-reset gate", int'(cpu_rdata), 8'hFF);
        check(ram_addr == RAM_AW'(0), "R1 re-reset ram", int'(ram_addr), 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule